// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block holds a small word memory and applies one atomic read-modify-write operation per request. A request names an operation, a word address, a primary operand, a compare operand, whether the old value should be returned, and whether max/min compare as signed numbers. The unit reads the addressed word, computes the new value, and writes it back. For returning requests it then presents the pre-modification value on a response channel.

The unit counts every compare-and-swap it executes and, separately, every compare-and-swap whose compare misses. An opcode outside the defined set raises an error flag that stays set until reset.

Control is a three-state machine with one process for the state register and one for the next state and outputs:
- **IDLE** accepts a request (`req_ready` high). When `req_valid` is seen, the request is latched and the machine goes IDLE→EXEC.
- **EXEC** reads the word, writes the result, updates the counters and the error flag. It goes EXEC→RESP for a legal returning request and EXEC→IDLE otherwise.
- **RESP** holds the response until `rsp_ready` is high, then goes RESP→IDLE.

Because only one request is in flight at a time, operations to any address are serialized.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Opcodes are 4 bits. AND=0, OR=1, XOR=2, EXCH=4, ADD=5 and SUB=6 write stored&op, stored|op, stored^op, op, stored+op and stored−op respectively. Arithmetic wraps at the word width.
- R2: Compare-and-swap (opcode 3) writes the operand only when the stored word equals the compare operand. Otherwise the word is left unchanged.
- R3: Every compare-and-swap increments `cas_attempts`. A compare-and-swap whose compare misses also increments `cas_fails`. Both counters change one edge after the EXEC state is entered.
- R4: INC (7) and DEC (8) add or subtract exactly one and wrap at the word width, regardless of the operand.
- R5: MAX (9) writes the operand only when it is greater than the stored word. MIN (10) writes it only when it is smaller. `req_signed`=1 compares as two's complement and 0 compares as unsigned.
- R6: With `req_ret`=1, a response carrying the value read before modification becomes valid after the EXEC edge. With `req_ret`=0, memory is updated and no response is produced.
- R7: A request issued in the first idle cycle after another request to the same address observes that request's result.
- R8: While a response is valid and `rsp_ready` is low, `rsp_data` stays stable, `rsp_valid` stays high and `req_ready` stays low.
- R9: Opcodes 11 to 15 set `err_flag`, which stays set until reset. They leave memory and counters unchanged and produce no response.
- R10: After reset, every word reads zero, both counters and `err_flag` are zero, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Word address |
| req_operand | input | DW | Primary operand (swap value for compare-and-swap) |
| req_compare | input | DW | Compare value for compare-and-swap |
| req_ret | input | 1 | 1 = return the old value |
| req_signed | input | 1 | 1 = signed compare for max/min |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DW | Word value before modification |
| err_flag | output | 1 | Sticky illegal-opcode flag |
| cas_attempts | output | CW | Compare-and-swap count |
| cas_fails | output | CW | Failed compare-and-swap count |

## Verification
A request driven before rising edge 1 is accepted at that edge. Memory, the counters and the error flag change at edge 2, and `rsp_valid` with the old value is visible after edge 2. The response drops at the first edge where `rsp_ready` is high. The bench drives and samples only on falling edges. It reads the response, the counters and the flag half a cycle after edge 2, and checks that `req_ready` is high again at the falling edge after a non-returning operation completes or after the response is taken. Memory contents are read back through returning OR-with-zero requests and compared against a bench model.

// File: rtl/atom_pkg.sv
package atom_pkg;
    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_CAS  = 4'd3,
        OP_EXCH = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_MAX  = 4'd9,
        OP_MIN  = 4'd10
    } atom_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } atom_state_e;

    localparam int unsigned OP_LAST = 10;
endpackage

// File: rtl/atom_decode.sv
module atom_decode
    import atom_pkg::*;
(
    input  logic [3:0] op_code,
    output logic       legal,
    output logic       is_cas
);
    always_comb begin
        legal  = (32'(op_code) <= OP_LAST);
        is_cas = (op_code == OP_CAS);
    end
endmodule

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] compare,
    input  logic          signed_cmp,
    output logic [DW-1:0] new_val,
    output logic          cas_miss
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic op_gt;
    logic op_lt;

    always_comb begin
        if (signed_cmp) begin
            op_gt = $signed(operand) > $signed(old_val);
            op_lt = $signed(operand) < $signed(old_val);
        end else begin
            op_gt = operand > old_val;
            op_lt = operand < old_val;
        end
    end

    always_comb begin
        cas_miss = (old_val != compare);
        new_val  = old_val;
        unique case (op_code)
            OP_AND:  new_val = old_val & operand;
            OP_OR:   new_val = old_val | operand;
            OP_XOR:  new_val = old_val ^ operand;
            OP_CAS:  new_val = cas_miss ? old_val : operand;
            OP_EXCH: new_val = operand;
            OP_ADD:  new_val = old_val + operand;
            OP_SUB:  new_val = old_val - operand;
            OP_INC:  new_val = old_val + ONE;
            OP_DEC:  new_val = old_val - ONE;
            OP_MAX:  new_val = op_gt ? operand : old_val;
            OP_MIN:  new_val = op_lt ? operand : old_val;
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/atom_mem.sv
module atom_mem #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    words[g] <= '0;
                end else if (wr_en && (wr_addr == AW'(g))) begin
                    words[g] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atom_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_operand,
    input  logic [DW-1:0] req_compare,
    input  logic          req_ret,
    input  logic          req_signed,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic          err_flag,
    output logic [CW-1:0] cas_attempts,
    output logic [CW-1:0] cas_fails
);
    atom_state_e st_q, st_nx;

    logic [3:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] opnd_q;
    logic [DW-1:0] cmp_q;
    logic          ret_q;
    logic          sgn_q;

    logic [DW-1:0] rd_data;
    logic [DW-1:0] new_val;
    logic          legal;
    logic          is_cas;
    logic          cas_miss;
    logic          wr_en;
    logic          accept;
    logic [DW-1:0] rsp_q;
    logic          err_q;
    logic [CW-1:0] att_q;
    logic [CW-1:0] fail_q;

    atom_decode u_dec (
        .op_code (op_q),
        .legal   (legal),
        .is_cas  (is_cas)
    );

    atom_alu #(.DW(DW)) u_alu (
        .op_code    (op_q),
        .old_val    (rd_data),
        .operand    (opnd_q),
        .compare    (cmp_q),
        .signed_cmp (sgn_q),
        .new_val    (new_val),
        .cas_miss   (cas_miss)
    );

    atom_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (addr_q),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (addr_q),
        .wr_data (new_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // next state and outputs
    always_comb begin
        st_nx     = st_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        wr_en     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) st_nx = ST_EXEC;
            end
            ST_EXEC: begin
                wr_en = legal;
                st_nx = (legal && ret_q) ? ST_RESP : ST_IDLE;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (rsp_ready) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            addr_q <= '0;
            opnd_q <= '0;
            cmp_q  <= '0;
            ret_q  <= 1'b0;
            sgn_q  <= 1'b0;
        end else if (accept) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            opnd_q <= req_operand;
            cmp_q  <= req_compare;
            ret_q  <= req_ret;
            sgn_q  <= req_signed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q  <= '0;
            err_q  <= 1'b0;
            att_q  <= '0;
            fail_q <= '0;
        end else if (st_q == ST_EXEC) begin
            rsp_q <= rd_data;
            if (!legal) err_q <= 1'b1;
            if (is_cas) begin
                att_q <= att_q + CW'(1);
                if (cas_miss) fail_q <= fail_q + CW'(1);
            end
        end
    end

    assign rsp_data     = rsp_q;
    assign err_flag     = err_q;
    assign cas_attempts = att_q;
    assign cas_fails    = fail_q;
endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk #(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [DW-1:0] rsp_data,
    input logic          err_flag,
    input logic [CW-1:0] cas_attempts,
    input logic [CW-1:0] cas_fails
);
    // R8
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

    // R8
    resp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R7
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !rsp_valid);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R3
    fail_needs_attempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fails != $past(cas_fails)) |-> (cas_attempts != $past(cas_attempts)));
endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .err_flag     (err_flag),
    .cas_attempts (cas_attempts),
    .cas_fails    (cas_fails)
);

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int CW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [3:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_operand = '0;
    logic [DW-1:0] req_compare = '0;
    logic          req_ret = 1'b0;
    logic          req_signed = 1'b0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [DW-1:0] rsp_data;
    logic          err_flag;
    logic [CW-1:0] cas_attempts;
    logic [CW-1:0] cas_fails;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] model [DEPTH];
    logic [CW-1:0] m_att = '0;
    logic [CW-1:0] m_fail = '0;
    logic          m_err = 1'b0;

    always #10 clk = ~clk;

    atomic_rmw_unit #(.DW(DW), .AW(AW), .CW(CW)) i_atomic_rmw_unit (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_new(input int op, input logic [DW-1:0] o,
            input logic [DW-1:0] a, input logic [DW-1:0] c, input bit s);
        bit gt, lt;
        gt = s ? ($signed(a) > $signed(o)) : (a > o);
        lt = s ? ($signed(a) < $signed(o)) : (a < o);
        case (op)
            0: return o & a;
            1: return o | a;
            2: return o ^ a;
            3: return (o == c) ? a : o;
            4: return a;
            5: return o + a;
            6: return o - a;
            7: return o + 1;
            8: return o - 1;
            9: return gt ? a : o;
            10: return lt ? a : o;
            default: return o;
        endcase
    endfunction

    // One request; starts and ends at a falling edge with the unit idle.
    task automatic do_op(input int op, input int addr, input logic [DW-1:0] opnd,
            input logic [DW-1:0] cmp, input bit ret, input bit sgn, input int hold,
            input string req);
        logic [DW-1:0] old;
        bit legal;
        legal = (op <= 10);
        old = model[addr];
        chk(req_ready == 1'b1, "R8 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_op = 4'(op); req_addr = AW'(addr);
        req_operand = opnd; req_compare = cmp; req_ret = ret; req_signed = sgn;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        if (legal) model[addr] = ref_new(op, old, opnd, cmp, sgn);
        else m_err = 1'b1;
        if (op == 3) begin
            m_att++;
            if (old != cmp) m_fail++;
        end
        chk(cas_attempts == m_att, "R3 attempts", 64'(cas_attempts), 64'(m_att));
        chk(cas_fails == m_fail, "R3 fails", 64'(cas_fails), 64'(m_fail));
        chk(err_flag == m_err, "R9 err_flag", 64'(err_flag), 64'(m_err));
        if (ret && legal) begin
            chk(rsp_valid == 1'b1, "R6 rsp_valid", 64'(rsp_valid), 64'd1);
            chk(rsp_data == old, req, 64'(rsp_data), 64'(old));
            for (int h = 0; h < hold; h++) begin
                @(posedge clk); @(negedge clk);
                chk(rsp_valid && rsp_data == old, "R8 held response", 64'(rsp_data), 64'(old));
                chk(req_ready == 1'b0, "R8 ready low while held", 64'(req_ready), 64'd0);
            end
            rsp_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            rsp_ready = 1'b0;
        end
        chk(rsp_valid == 1'b0, "R6 no response pending", 64'(rsp_valid), 64'd0);
    endtask

    task automatic read_word(input int addr, input string req);
        do_op(1, addr, '0, '0, 1'b1, 1'b0, 0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(err_flag == 1'b0 && cas_attempts == 0 && cas_fails == 0, "R10 status",
            64'(err_flag), 64'd0);
        read_word(0, "R10 word zero");
        read_word(15, "R10 word zero");

        // R1 logic and arithmetic
        do_op(4, 2, 32'hF0F0_1234, '0, 1'b1, 1'b0, 0, "R1 EXCH");
        do_op(0, 2, 32'h0FF0_FF00, '0, 1'b1, 1'b0, 0, "R1 AND");
        do_op(2, 2, 32'hFFFF_FFFF, '0, 1'b0, 1'b0, 0, "R1 XOR");
        do_op(5, 2, 32'hFFFF_FFFF, '0, 1'b1, 1'b0, 0, "R1 ADD wrap");
        do_op(6, 2, 32'h1000_0000, '0, 1'b1, 1'b0, 0, "R1 SUB");
        read_word(2, "R1 final value");
        // R2 / R3 compare-and-swap hit then miss
        do_op(3, 3, 32'h55, 32'h0, 1'b1, 1'b0, 0, "R2 CAS hit");
        do_op(3, 3, 32'h66, 32'h0, 1'b1, 1'b0, 0, "R2 CAS miss");
        read_word(3, "R2 CAS result");
        // R4 wrap both ways, operand ignored
        do_op(8, 4, 32'h1234, '0, 1'b1, 1'b0, 0, "R4 DEC wrap");
        do_op(7, 4, 32'h9999, '0, 1'b1, 1'b0, 0, "R4 INC wrap");
        read_word(4, "R4 INC DEC");
        // R5 signed vs unsigned
        do_op(4, 5, 32'h0000_0005, '0, 1'b0, 1'b0, 0, "R5 setup");
        do_op(9, 5, 32'hFFFF_FFFF, '0, 1'b1, 1'b1, 0, "R5 signed MAX no write");
        do_op(9, 5, 32'hFFFF_FFFF, '0, 1'b1, 1'b0, 0, "R5 unsigned MAX write");
        do_op(10, 5, 32'h0000_0003, '0, 1'b1, 1'b0, 0, "R5 unsigned MIN");
        do_op(10, 5, 32'h8000_0000, '0, 1'b1, 1'b1, 0, "R5 signed MIN");
        read_word(5, "R5 result");
        // R7 back-to-back same address
        do_op(5, 6, 32'd10, '0, 1'b0, 1'b0, 0, "R7 first");
        do_op(5, 6, 32'd7, '0, 1'b1, 1'b0, 0, "R7 second sees first");
        read_word(6, "R7 result");
        // R8 back-pressure
        do_op(7, 7, '0, '0, 1'b1, 1'b0, 3, "R8 held INC");
        // R9 illegal opcode
        do_op(12, 7, 32'hDEAD, '0, 1'b1, 1'b0, 0, "R9 illegal");
        read_word(7, "R9 memory unchanged");
        do_op(15, 7, 32'hBEEF, '0, 1'b0, 1'b0, 0, "R9 illegal again");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op, addr;
            logic [DW-1:0] a, c;
            op = int'($urandom_range(0, 11));
            addr = int'($urandom_range(0, DEPTH - 1));
            a = ($urandom_range(0, 1) == 0) ? DW'($urandom_range(0, 8)) : DW'($urandom);
            c = ($urandom_range(0, 1) == 0) ? model[addr] : DW'($urandom);
            do_op(op, addr, a, c, 1'(($urandom_range(0, 3) != 0)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 2)), "R6 random old value");
        end
        for (int i = 0; i < DEPTH; i++) read_word(i, "R1 random final contents");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule